// File: doc/BRIEF.md
# Burst Ordering Target Controller

This block serves the target side of a 32-bit multiplexed address/data bus. When an initiator opens a transaction with a memory command, the controller captures the address phase. It classifies the requested burst order from the two lowest address bits. It then supplies one internal word address for each data phase that completes. It also decides when the target ends a burst on its own, with a disconnect. That decision depends on the transfer direction, the burst order and a programmable cache line size.

A data phase completes in any cycle where both the initiator-ready input and the target-ready output are high. The controller ends a burst in one of two ways. It can raise the stop output together with target ready, which ends the burst after that beat. Or it can raise stop without target ready, which ends the burst with no further data. The cache line size is given in 32-bit words and must be zero or a power of two. A parity bit computed over the whole address phase is held for the length of the transaction.

Top module: `bo_burst_target`

## Requirements
- R1: When `frame_start` is high in a cycle where the controller is idle, and `cmd` is a memory command, the controller latches `ad[31:2]` as `word_addr` and shows `busy` high from the next cycle. Any other command code is ignored and `busy` stays low.
- R2: A data phase completes when `irdy` and `trdy` are both high at a clock edge. `word_addr` advances by one word (4 bytes) after each completed phase. It holds its value while `irdy` is low.
- R3: `addr_par` is the even parity (XOR) of all 32 `ad` bits, including bits [1:0], together with the 4 `cmd` bits, all captured at the address phase. It stays constant for the whole transaction.
- R4: Single-beat mode applies when the low address bits are 01 or 11 (reserved), or when they are 10 (wrap) while `cls_words` is zero. In this mode the first phase is offered with `trdy` high and `stop` low. After that phase completes without `last`, the controller drives `trdy` low and `stop` high until `irdy` is seen, and then returns to idle.
- R5: When the low address bits are 10 and `cls_words` is non-zero, the burst is accepted and proceeds as a linear incrementing burst from the latched word address.
- R6: For reads, when `cls_words` is non-zero, `stop` is raised together with `trdy` on the phase whose next word address is a multiple of `cls_words`. Completing that phase ends the transaction.
- R7: A read with `cls_words` equal to zero in linear mode never raises `stop`. It continues until the initiator marks its last phase.
- R8: Writes never raise `stop` at a line boundary. A write ends only when a phase completes with `last` high.
- R9: Read commands are 0110, 1100 and 1110, and all three behave identically. Write commands are 0111 and 1111, and both behave identically.
- R10: `burst_kind` reports the classification latched at the address phase: 00 for linear, 01 for wrap converted to linear, and 10 for single-beat.
- R11: While reset is asserted, and whenever the controller is idle, `busy`, `trdy` and `stop` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_start | input | 1 | Address-phase strobe |
| cmd | input | 4 | Bus command code |
| ad | input | 32 | Address presented in the address phase |
| cls_words | input | 8 | Cache line size in words (0 or a power of two) |
| irdy | input | 1 | Initiator ready |
| last | input | 1 | Initiator marks the current phase as its final one |
| busy | output | 1 | A transaction is in progress |
| trdy | output | 1 | Target ready |
| stop | output | 1 | Target disconnect request |
| word_addr | output | 30 | Internal word address of the current data phase |
| beat_done | output | 1 | A data phase completes this cycle |
| burst_kind | output | 2 | Latched burst classification |
| addr_par | output | 1 | Parity over the address phase |

## Verification
The bench targets read bursts that start in the middle of a line, so that the first disconnect comes after only a few beats. It also covers a line size of one word, where the very first beat already carries the disconnect. A design that computed the boundary from the start of the burst, or from the current word instead of the next one, would stop a beat early or late, and the final `word_addr` would be wrong. Wrap requests are run with a zero and a non-zero line size, and reserved encodings with and without `last` on the first beat. These runs catch a design that refuses a legal wrap, or that streams data where it must disconnect without data. A stall cycle inside each burst exposes an address counter that advances without a completed phase. Writes across line boundaries expose a disconnect that fires for the wrong direction.

// File: rtl/bo_pkg.sv
package bo_pkg;

  typedef enum logic [1:0] {
    KIND_LINEAR   = 2'b00,
    KIND_WRAP_LIN = 2'b01,
    KIND_SINGLE   = 2'b10
  } burst_kind_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_DATA = 2'b01,
    ST_HALT = 2'b10
  } term_state_t;

  // Read family: plain read, multiple read, line read (R9)
  function automatic logic cmd_is_read(input logic [3:0] c);
    return (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);
  endfunction

  // Write family: plain write, write-and-invalidate (R9)
  function automatic logic cmd_is_write(input logic [3:0] c);
    return (c == 4'b0111) || (c == 4'b1111);
  endfunction

  // Classification of the two low address bits given the line size (R4, R5, R10)
  function automatic burst_kind_t classify(input logic [1:0] low, input logic cls_zero);
    burst_kind_t k;
    case (low)
      2'b00:   k = KIND_LINEAR;
      2'b10:   k = cls_zero ? KIND_SINGLE : KIND_WRAP_LIN;
      default: k = KIND_SINGLE;
    endcase
    return k;
  endfunction

  // True when the word after 'word' begins a new line of 'cls' words (power of two)
  function automatic logic line_last(input logic [31:0] word, input logic [31:0] cls);
    logic [31:0] nxt;
    nxt = word + 32'd1;
    return (cls != 32'd0) && ((nxt & (cls - 32'd1)) == 32'd0);
  endfunction

endpackage

// File: rtl/bo_cmd_decode.sv
module bo_cmd_decode
  import bo_pkg::*;
#(
  parameter int CLS_W = 8
) (
  input  logic [3:0]       cmd,
  input  logic [1:0]       ad_low,
  input  logic [CLS_W-1:0] cls_words,
  output logic             is_mem,
  output logic             is_rd,
  output burst_kind_t      kind
);

  logic rd_hit;
  logic wr_hit;

  always_comb begin
    rd_hit = cmd_is_read(cmd);
    wr_hit = cmd_is_write(cmd);
    is_mem = rd_hit | wr_hit;
    is_rd  = rd_hit;
    kind   = classify(ad_low, cls_words == '0);
  end

  always_comb begin
    assert_cmd_exclusive_R9: assert (!(rd_hit && wr_hit))
      else $error("read and write decode both hit");
  end

endmodule

// File: rtl/bo_addr_gen.sv
module bo_addr_gen #(
  parameter int WORD_W = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [WORD_W-1:0] load_val,
  input  logic              step,
  output logic [WORD_W-1:0] word
);

  logic [WORD_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     word_q <= '0;
    else if (load)  word_q <= load_val;
    else if (step)  word_q <= word_q + 1'b1;
  end

  assign word = word_q;

  assert_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (word == $past(word) + 1'b1));

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !load) |=> $stable(word));

endmodule

// File: rtl/bo_term_ctrl.sv
module bo_term_ctrl
  import bo_pkg::*;
#(
  parameter int WORD_W = 30,
  parameter int CLS_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  burst_kind_t       start_kind,
  input  logic              start_rd,
  input  logic [CLS_W-1:0]  start_cls,
  input  logic              irdy,
  input  logic              last,
  input  logic [WORD_W-1:0] word,
  output logic              busy,
  output logic              trdy,
  output logic              stop,
  output logic              beat_done,
  output burst_kind_t       kind
);

  term_state_t       state_q, state_d;
  burst_kind_t       kind_q;
  logic              rd_q;
  logic [CLS_W-1:0]  cls_q;
  logic              at_line_end;
  logic              ends_here;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kind_q <= KIND_LINEAR;
      rd_q   <= 1'b0;
      cls_q  <= '0;
    end else if (start) begin
      kind_q <= start_kind;
      rd_q   <= start_rd;
      cls_q  <= start_cls;
    end
  end

  always_comb begin
    at_line_end = rd_q && (kind_q != KIND_SINGLE) && line_last(32'(word), 32'(cls_q));
    trdy        = (state_q == ST_DATA);
    stop        = (state_q == ST_HALT) || ((state_q == ST_DATA) && at_line_end);
    beat_done   = irdy && trdy;
    ends_here   = beat_done && (last || stop);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = ST_DATA;
      ST_DATA: begin
        if (ends_here)                            state_d = ST_IDLE;
        else if (beat_done && kind_q == KIND_SINGLE) state_d = ST_HALT;
      end
      ST_HALT: if (irdy) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign busy = (state_q != ST_IDLE);
  assign kind = kind_q;

  assert_halt_no_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HALT) |-> (stop && !trdy));

  assert_single_one_beat_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy && kind_q == KIND_SINGLE && beat_done && !last) |=> (stop && !trdy));

  assert_write_no_stop_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (trdy && !rd_q) |-> !stop);

  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!trdy && !stop));

  assert_line_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_done && stop) |=> !busy);

endmodule

// File: rtl/bo_burst_target.sv
module bo_burst_target
  import bo_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CLS_W  = 8,
  localparam int WORD_W = ADDR_W - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic [3:0]        cmd,
  input  logic [ADDR_W-1:0] ad,
  input  logic [CLS_W-1:0]  cls_words,
  input  logic              irdy,
  input  logic              last,
  output logic              busy,
  output logic              trdy,
  output logic              stop,
  output logic [WORD_W-1:0] word_addr,
  output logic              beat_done,
  output logic [1:0]        burst_kind,
  output logic              addr_par
);

  logic        dec_mem;
  logic        dec_rd;
  burst_kind_t dec_kind;
  burst_kind_t cur_kind;
  logic        start;
  logic        par_q;

  bo_cmd_decode #(.CLS_W(CLS_W)) u_dec (
    .cmd       (cmd),
    .ad_low    (ad[1:0]),
    .cls_words (cls_words),
    .is_mem    (dec_mem),
    .is_rd     (dec_rd),
    .kind      (dec_kind)
  );

  assign start = frame_start && dec_mem && !busy;

  bo_addr_gen #(.WORD_W(WORD_W)) u_addr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (ad[ADDR_W-1:2]),
    .step     (beat_done),
    .word     (word_addr)
  );

  bo_term_ctrl #(.WORD_W(WORD_W), .CLS_W(CLS_W)) u_term (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .start_kind (dec_kind),
    .start_rd   (dec_rd),
    .start_cls  (cls_words),
    .irdy       (irdy),
    .last       (last),
    .word       (word_addr),
    .busy       (busy),
    .trdy       (trdy),
    .stop       (stop),
    .beat_done  (beat_done),
    .kind       (cur_kind)
  );

  // Parity covers every address bit, low pair included, plus the command
  always_ff @(posedge clk) begin
    if (!rst_n)     par_q <= 1'b0;
    else if (start) par_q <= ^{ad, cmd};
  end

  assign addr_par   = par_q;
  assign burst_kind = cur_kind;

  assert_latch_R1: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && word_addr == $past(ad[ADDR_W-1:2])));

  assert_ignore_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(frame_start && dec_mem)) |=> !busy);

  assert_parity_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(addr_par));

  assert_kind_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start) |=> $stable(burst_kind));

endmodule

// File: tb/tb_bo_burst_target.sv
`timescale 1ns/1ps
module tb_bo_burst_target;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_start = 1'b0;
  logic [3:0]  cmd = 4'b0000;
  logic [31:0] ad = '0;
  logic [7:0]  cls_words = '0;
  logic        irdy = 1'b0;
  logic        last = 1'b0;
  logic        busy, trdy, stop, beat_done, addr_par;
  logic [29:0] word_addr;
  logic [1:0]  burst_kind;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  bo_burst_target dut (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .cmd(cmd), .ad(ad),
    .cls_words(cls_words), .irdy(irdy), .last(last), .busy(busy), .trdy(trdy),
    .stop(stop), .word_addr(word_addr), .beat_done(beat_done),
    .burst_kind(burst_kind), .addr_par(addr_par)
  );

  localparam int NV = 10;
  localparam logic [3:0]  V_CMD [NV] = '{4'b0110, 4'b0111, 4'b1110, 4'b1111, 4'b0110,
                                         4'b0110, 4'b0111, 4'b1100, 4'b0110, 4'b0111};
  localparam logic [31:0] V_AD  [NV] = '{32'h0000_1000, 32'h0000_1000, 32'h0000_1014,
                                         32'h0000_101C, 32'h0000_2002, 32'h0000_2002,
                                         32'h0000_2001, 32'h0000_3000, 32'h0000_300C,
                                         32'h0000_2003};
  localparam logic [7:0]  V_CLS [NV] = '{8'd8, 8'd8, 8'd8, 8'd4, 8'd0,
                                         8'd4, 8'd4, 8'd0, 8'd1, 8'd0};
  localparam int          V_N   [NV] = '{12, 12, 10, 5, 4, 6, 3, 6, 3, 1};

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_txn(input logic [3:0] c, input logic [31:0] a,
                         input logic [7:0] cl, input int n);
    bit rd, single, ended, exp_stop;
    logic [1:0] ek;
    logic [29:0] wa;
    rd = (c == 4'b0110) || (c == 4'b1100) || (c == 4'b1110);   // R9 read family
    if (a[1:0] == 2'b00)                ek = 2'b00;
    else if (a[1:0] == 2'b10 && cl != 0) ek = 2'b01;            // R5
    else                                ek = 2'b10;             // R4
    single = (ek == 2'b10);
    @(negedge clk);
    cls_words = cl; frame_start = 1'b1; cmd = c; ad = a; irdy = 1'b0; last = 1'b0;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R1 busy after memory command", 32'(busy), 32'd1);
    chk("R1 latched word address", 32'(word_addr), 32'(a[31:2]));
    chk("R3 address-phase parity", 32'(addr_par), 32'(^{a, c}));
    chk("R10 burst kind", 32'(burst_kind), 32'(ek));
    wa = a[31:2];
    ended = 1'b0;
    for (int k = 0; k < n && !ended; k++) begin
      if (k == 1) begin
        irdy = 1'b0;
        @(negedge clk);
        chk("R2 no advance while irdy low", 32'(word_addr), 32'(wa));
      end
      irdy = 1'b1;
      last = (k == n - 1);
      exp_stop = !single && rd && (cl != 0) && ((32'(wa) + 1) % 32'(cl) == 0);
      #1;
      chk("R2 trdy offered on data phase", 32'(trdy), 32'd1);
      chk(rd ? "R6/R7 read stop at line end" : "R8 write never stops",
          32'(stop), 32'(exp_stop));
      chk("R2 word address per phase", 32'(word_addr), 32'(wa));
      @(negedge clk);
      wa = wa + 1'b1;
      if (last || exp_stop) ended = 1'b1;
      else if (single) begin
        #1;
        chk("R4 disconnect without data trdy", 32'(trdy), 32'd0);
        chk("R4 disconnect without data stop", 32'(stop), 32'd1);
        @(negedge clk);
        ended = 1'b1;
      end
    end
    irdy = 1'b0; last = 1'b0;
    #1;
    chk("R6 R8 transaction ended", 32'(busy), 32'd0);
    chk("R11 idle trdy/stop low", 32'({trdy, stop}), 32'd0);
    chk("R2 final word address", 32'(word_addr), 32'(wa));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 reset busy", 32'(busy), 32'd0);
    chk("R11 reset trdy/stop", 32'({trdy, stop}), 32'd0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) run_txn(V_CMD[i], V_AD[i], V_CLS[i], V_N[i]);

    // R1: non-memory commands (I/O read, configuration read) are ignored
    @(negedge clk);
    frame_start = 1'b1; cmd = 4'b0010; ad = 32'h0000_4000;
    @(negedge clk);
    chk("R1 I/O command ignored", 32'(busy), 32'd0);
    cmd = 4'b1010;
    @(negedge clk);
    frame_start = 1'b0;
    chk("R1 config command ignored", 32'(busy), 32'd0);

    // R11: reset in the middle of a burst
    @(negedge clk);
    cls_words = 8'd8; frame_start = 1'b1; cmd = 4'b0111; ad = 32'h0000_5000;
    @(negedge clk);
    frame_start = 1'b0; irdy = 1'b1;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R11 reset during burst busy", 32'(busy), 32'd0);
    chk("R11 reset during burst trdy/stop", 32'({trdy, stop}), 32'd0);
    irdy = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule